// File: doc/BRIEF.md
# NRZI Word Serializing Transmitter

This block feeds a low-rate audio modulator from a stream of 16-bit data words. It shifts each word out least significant bit first, one bit on every bit-rate strobe, and turns the bits into NRZI line levels on a single transmit-data output. A 0 bit changes the line level and a 1 bit keeps it.

Words enter through a valid/ready handshake. A word is taken in only in the strobe cycle where the previous word has been used up. If no word is offered at that moment, an all-ones idle word is loaded in its place, so the line stays at a steady level. The shift register carries a marker bit above the data. When that marker reaches the bottom, a reload is due, so no separate bit counter is needed. The output is registered one strobe late: the level worked out on one strobe goes onto the line on the next strobe. The line therefore changes at a fixed point in each bit period.

Top module: `nrzi_word_tx`

## Requirements
- R1: After reset `txd_o` is 0 and the shift register is empty. The first strobe after reset is a reload.
- R2: `txd_o` changes only on a clock edge where `bit_stb_i` is high.
- R3: On each strobe, `txd_o` takes the level that was computed on the previous strobe. The first strobe after reset drives 0.
- R4: On each strobe the next level is computed from the current bit. A bit of 0 inverts the level and a bit of 1 keeps it.
- R5: The bits of a word are used least significant first, starting with bit 0, one per strobe. Bits 1 to 15 follow on the next 15 strobes.
- R6: A reload happens on every 16th strobe and on no other strobe. `ready_o` is high only in the cycle of a reload strobe.
- R7: In a reload cycle where `valid_i` is high, `word_i` is loaded. In every other cycle, `word_i` and `valid_i` have no effect on the line.
- R8: In a reload cycle where `valid_i` is low, the word 0xFFFF is loaded. During that word the line level stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle pulse, one per line bit |
| word_i | input | 16 | Data word to serialize |
| valid_i | input | 1 | `word_i` holds a word |
| ready_o | output | 1 | Word taken at this edge (reload strobe) |
| txd_o | output | 1 | NRZI transmit-data line |

## Verification
`ready_o` is combinational, so it is checked inside the strobe cycle, before the edge that takes the word. The level for a bit is computed at that bit's strobe edge, and `txd_o` shows it only after the following strobe edge. The scoreboard therefore queues the level it predicts for each strobe, and the monitor compares it on the falling clock edge just after that strobe. Between strobes, the monitor checks on each clock edge that the line holds its level. During those cycles `word_i` carries changing junk values, and the line must not react to them.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  localparam int unsigned WORD_W_DEF = 16;

  // NRZI rule: a 0 bit flips the line, a 1 bit holds it
  function automatic logic nrzi_next(input logic cur, input logic bit_v);
    return bit_v ? cur : ~cur;
  endfunction
endpackage

// File: rtl/nrzi_word_shifter.sv
module nrzi_word_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] IDLE_WORD = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              bit_o
);
  localparam int unsigned SH_W = WORD_W + 1;

  logic [SH_W-1:0] sh_q, sh_eff;
  logic            reload_due;

  // marker at the top; value <= 1 means the word is used up
  assign reload_due = (sh_q[SH_W-1:1] == '0);
  assign ready_o    = bit_stb_i & reload_due;
  assign sh_eff     = reload_due ? {1'b1, (valid_i ? word_i : IDLE_WORD)} : sh_q;
  assign bit_o      = sh_eff[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (bit_stb_i) sh_q <= sh_eff >> 1;
  end

  assert_empty_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (sh_q[SH_W-1] == 1'b0) && (sh_q[SH_W-2] == 1'b1));
endmodule

// File: rtl/nrzi_level_gen.sv
module nrzi_level_gen
  import nrzi_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic bit_i,
  output logic txd_o
);
  logic lvl_q, txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      txd_q <= 1'b0;
    end else if (bit_stb_i) begin
      txd_q <= lvl_q;                    // drive the previous result first
      lvl_q <= nrzi_next(lvl_q, bit_i);
    end
  end

  assign txd_o = txd_q;

  assert_txd_lags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_i |=> txd_o == $past(lvl_q));
  assert_zero_toggles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !bit_i) |=> lvl_q != $past(lvl_q));
  assert_one_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && bit_i) |=> $stable(lvl_q));
endmodule

// File: rtl/nrzi_word_tx.sv
module nrzi_word_tx
  import nrzi_tx_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic cur_bit;

  nrzi_word_shifter #(.WORD_W(WORD_W), .IDLE_WORD('1)) u_shift (
    .clk_i, .rst_ni, .bit_stb_i, .word_i, .valid_i,
    .ready_o, .bit_o(cur_bit)
  );

  nrzi_level_gen u_level (
    .clk_i, .rst_ni, .bit_stb_i, .bit_i(cur_bit), .txd_o
  );

  // independent strobe counter to check the sentinel-driven reload period
  logic [CNT_W-1:0] stb_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stb_cnt_q <= LAST;
    else if (bit_stb_i) stb_cnt_q <= (stb_cnt_q == LAST) ? '0 : stb_cnt_q + 1'b1;
  end

  assert_reload_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_i |-> (ready_o == (stb_cnt_q == LAST)));
  assert_txd_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(txd_o));
  assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> cur_bit || !bit_stb_i);
endmodule

// File: tb/nrzi_word_tx_tb.sv
`timescale 1ns/1ps
module nrzi_word_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic [15:0] word = '0;
  logic        valid = 1'b0;
  logic        ready, txd;

  int checks = 0, errors = 0;
  logic exp_q[$];
  logic mnext = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  nrzi_word_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .word_i(word),
    .valid_i(valid), .ready_o(ready), .txd_o(txd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one word: 16 strobes, reload on the first; junk on word_i between strobes
  task automatic send_word(input logic [15:0] w, input logic v);
    logic [15:0] eff;
    eff = v ? w : 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      stb = 1'b1;
      valid = v;
      word = (i == 0) ? w : ~w ^ 16'(i * 16'h1357);
      exp_q.push_back(mnext);                       // R3: previous level goes out
      mnext = eff[i] ? mnext : ~mnext;              // R4/R5/R7/R8: LSB-first NRZI
      #1;
      chk(i == 0 ? "R6 ready at reload" : "R6 no ready mid-word", ready, i == 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        stb = 1'b0;
        valid = (k == 1);                           // R7: valid without reload is ignored
        word = 16'h0F0F ^ 16'(k * 16'h2222);
        #1;
        chk("R6 ready low without strobe", ready, 1'b0);
      end
    end
  endtask

  // monitor: compares after each strobe edge, checks quiet line otherwise
  initial begin
    logic prev;
    logic e;
    forever begin
      @(posedge clk);
      prev = txd;
      if (rst_n) begin
        if (stb) begin
          @(negedge clk);
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3: actual=%0b expected=<none>", txd);
          end else begin
            e = exp_q.pop_front();
            chk("R3/R4/R5 line level", txd, e);
          end
        end else begin
          @(negedge clk);
          chk("R2 line stable between strobes", txd, prev);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 txd reset", txd, 1'b0);
        chk("R1 ready low in reset", ready, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd after reset", txd, 1'b0);
        send_word(16'h0000, 1'b1);   // R4 all toggles
        send_word(16'hFFFF, 1'b1);   // R4 all holds
        send_word(16'hA5C3, 1'b1);   // R5 mixed
        send_word(16'h1234, 1'b0);   // R8 idle word
        send_word(16'h8001, 1'b1);   // R5 end bits
        send_word(16'h0000, 1'b0);   // R8 idle again
        send_word(16'h5A5A, 1'b1);   // flush
        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size() == 0, 1'b1);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule